// File: doc/BRIEF.md
# Tape Line Byte Packer with Block Checksum

This block sits between a bidirectional block-formatted tape transport and a byte-wide data channel. The tape carries three data lines and one mark line. Each tape step yields one 3-bit line, so a 6-bit byte takes two consecutive steps. The block keeps a line-phase toggle and packs the two lines of a read byte into one register. It then hands the byte to the channel as a single-cycle pulse. On a write it takes a byte from the channel and emits it as two 3-bit write lines. When the tape runs backwards it complements every line and swaps the byte halves, so the channel always sees bytes in forward form.

A running checksum covers the block. On each second step of a byte it absorbs the complement of the byte, which is a parity-of-zeros sum. The external mark decoder supplies three strobes. One marks the checksum positions: these exchange no data with the channel, and on a write they receive the checksum. One restarts the checksum. One closes the block, and at that point the sum must read all ones. Two sticky flags report problems: a checksum mismatch, and a channel that was not ready when a byte had to move.

Top module: `tape_byte_packer`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `rd_valid`, `wr_take`, `ck_err`, `incomplete` and `wr_line` are all 0.
- R2: Every register update happens only on a cycle where `step` is high, and its results appear on the outputs one cycle later. On a read step (`wr_mode`=0) with `blk_active`=1, phase 0 ORs the complemented-if-reverse line into byte bits 5..3 and phase 1 ORs it into bits 2..0. In the cycle after a phase-1 read step, `rd_valid` is high for exactly one cycle and carries the assembled byte.
- R3: In reverse (`rev`=1) each sensed line is XORed with 7 before it is stored. The delivered byte has its halves swapped: stored bits 2..0 appear on `rd_byte[5:3]`. `rd_rev` repeats the direction of the delivering step.
- R4: The phase is 0 after any step with `blk_active`=0, and it toggles on every step with `blk_active`=1.
- R5: A read step or write fetch with `ck_slot`=1 delivers no byte (`rd_valid` stays 0) and takes none from the channel (`wr_take` stays 0).
- R6: A write step with `blk_active`=1 in phase 1 (the fetch step) reloads the byte register. Outside checksum slots it loads `chan_wdata` and pulses `wr_take` for one cycle. A read step with `blk_active`=1 in phase 1 clears the register to 0.
- R7: On a write step, `wr_line[2:0]` is the byte's bits 5..3 in phase 0 or bits 2..0 in phase 1, XORed with 7 in reverse. `wr_line[3]` copies the mark line `sense[3]`. After a read step `wr_line` is 0.
- R8: A write fetch step with `ck_slot`=1 loads the checksum value of that step into the byte register in place of channel data.
- R9: On every phase-1 step the checksum becomes checksum XOR (NOT byte), where byte includes the line sensed in that step. A step with `ck_open`=1 first clears the checksum to 0.
- R10: A step with `blk_close`=1 and `blk_active`=1 sets `ck_err` when the checksum after that step is not 77 octal. `ck_err` holds until reset.
- R11: `incomplete` is set when a byte is delivered while `chan_ready`=0, or when a byte is taken while `chan_wvalid`=0. It holds until reset.
- R12: A reverse write fetch swaps the halves of the loaded byte, so its bits 2..0, complemented, go out first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One-cycle tape step strobe |
| sense | input | 4 | Sensed line: bits 2..0 data, bit 3 mark |
| rev | input | 1 | Tape moving in reverse |
| wr_mode | input | 1 | 1 = write, 0 = read |
| blk_active | input | 1 | Block transfer active |
| ck_slot | input | 1 | Current position is a checksum slot |
| ck_open | input | 1 | Restart checksum at this step |
| blk_close | input | 1 | End of block: test checksum at this step |
| chan_wdata | input | 6 | Byte offered by the channel for writing |
| chan_wvalid | input | 1 | Channel has a write byte ready |
| chan_ready | input | 1 | Channel can accept a read byte |
| wr_line | output | 4 | Line to write: bit 3 mark, bits 2..0 data |
| rd_valid | output | 1 | One-cycle pulse: read byte valid |
| rd_byte | output | 6 | Read byte in forward order |
| rd_rev | output | 1 | Direction of the delivered byte |
| wr_take | output | 1 | One-cycle pulse: channel byte consumed |
| ck_err | output | 1 | Sticky checksum error |
| incomplete | output | 1 | Sticky channel overrun/underrun |

## Verification
On every cycle, the assertions check the handshake shape: pulses last one cycle, a read pulse and a take pulse never coincide, and every pulse follows a step in the right mode outside a checksum slot. They also check that both flags stay set and that the write line is idle after read steps. The byte values depend on phase, direction, checksum folding and fetch timing, so only the bench's reference model can show them: packed halves, reverse complement and swap, checksum insertion, and the pass/fail result at block close.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
   typedef struct packed {
      logic rev;
      logic wr;
      logic act;
      logic slot;
   } tbp_ctl_t;
endpackage

// File: rtl/tbp_byte_reg.sv
module tbp_byte_reg
   import tbp_pkg::*;
#(
   parameter int LINE_W = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step,
   input  tbp_ctl_t            ctl,
   input  logic [LINE_W-1:0]   line_in,
   input  logic                load_en,
   input  logic [2*LINE_W-1:0] load_val,
   output logic [2*LINE_W-1:0] byte_q,
   output logic [2*LINE_W-1:0] filled,
   output logic                ph_q
);
   localparam int BW = 2 * LINE_W;

   logic [BW-1:0] merge;
   logic [BW-1:0] byte_d;
   logic          ph_d;

   always_comb begin
      merge = '0;
      if (ctl.act && !ctl.wr) begin
         if (ph_q) merge[LINE_W-1:0]  = line_in;
         else      merge[BW-1:LINE_W] = line_in;
      end
      filled = byte_q | merge;
      ph_d   = ctl.act & ~ph_q;
      if (ctl.act && ph_q) byte_d = load_en ? load_val : '0;
      else                 byte_d = filled;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_q <= '0;
         ph_q   <= 1'b0;
      end else if (step) begin
         byte_q <= byte_d;
         ph_q   <= ph_d;
      end
   end
endmodule

// File: rtl/tbp_cksum.sv
module tbp_cksum #(
   parameter int W           = 6,
   parameter bit ZERO_PARITY = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         open,
   input  logic         fold,
   input  logic [W-1:0] data,
   output logic [W-1:0] sum_next
);
   logic [W-1:0] sum_q;
   logic [W-1:0] term;
   logic [W-1:0] base;

   generate
      if (ZERO_PARITY) begin : g_zeros
         assign term = ~data;
      end else begin : g_ones
         assign term = data;
      end
   endgenerate

   assign base     = open ? '0 : sum_q;
   assign sum_next = fold ? (base ^ term) : base;

   always_ff @(posedge clk) begin
      if (!rst_n)    sum_q <= '0;
      else if (step) sum_q <= sum_next;
   end
endmodule

// File: rtl/tape_byte_packer.sv
module tape_byte_packer
   import tbp_pkg::*;
#(
   parameter int LINE_W      = 3,
   parameter bit ZERO_PARITY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                step,
   input  logic [LINE_W:0]     sense,
   input  logic                rev,
   input  logic                wr_mode,
   input  logic                blk_active,
   input  logic                ck_slot,
   input  logic                ck_open,
   input  logic                blk_close,
   input  logic [2*LINE_W-1:0] chan_wdata,
   input  logic                chan_wvalid,
   input  logic                chan_ready,
   output logic [LINE_W:0]     wr_line,
   output logic                rd_valid,
   output logic [2*LINE_W-1:0] rd_byte,
   output logic                rd_rev,
   output logic                wr_take,
   output logic                ck_err,
   output logic                incomplete
);
   localparam int BW = 2 * LINE_W;
   localparam logic [LINE_W-1:0] CMASK = {LINE_W{1'b1}};
   localparam logic [BW-1:0]     GOOD  = {BW{1'b1}};

   generate
      if (LINE_W < 1) begin : g_bad_width
         $error("LINE_W must be at least 1");
      end
   endgenerate

   function automatic logic [BW-1:0] swap_h(input logic [BW-1:0] v);
      return {v[LINE_W-1:0], v[BW-1:LINE_W]};
   endfunction

   tbp_ctl_t          ctl;
   logic [LINE_W-1:0] cpl;
   logic [BW-1:0]     byte_q, filled, ck_next, fetch_src, load_val;
   logic              ph_q, deliver, fetch, take, close_bad;
   logic [LINE_W-1:0] out_half;

   assign ctl = '{rev: rev, wr: wr_mode, act: blk_active, slot: ck_slot};
   assign cpl = rev ? CMASK : '0;

   assign fetch     = wr_mode & blk_active & ph_q;
   assign take      = fetch & ~ck_slot;
   assign deliver   = ~wr_mode & blk_active & ph_q & ~ck_slot;
   assign fetch_src = ck_slot ? ck_next : chan_wdata;
   assign load_val  = rev ? swap_h(fetch_src) : fetch_src;
   assign out_half  = ph_q ? byte_q[LINE_W-1:0] : byte_q[BW-1:LINE_W];
   assign close_bad = blk_close & blk_active & (ck_next != GOOD);

   tbp_byte_reg #(.LINE_W(LINE_W)) u_byte (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .ctl      (ctl),
      .line_in  (sense[LINE_W-1:0] ^ cpl),
      .load_en  (fetch),
      .load_val (load_val),
      .byte_q   (byte_q),
      .filled   (filled),
      .ph_q     (ph_q)
   );

   tbp_cksum #(.W(BW), .ZERO_PARITY(ZERO_PARITY)) u_ck (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .open     (ck_open),
      .fold     (ph_q),
      .data     (filled),
      .sum_next (ck_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_line    <= '0;
         rd_valid   <= 1'b0;
         rd_byte    <= '0;
         rd_rev     <= 1'b0;
         wr_take    <= 1'b0;
         ck_err     <= 1'b0;
         incomplete <= 1'b0;
      end else begin
         rd_valid <= step & deliver;
         wr_take  <= step & take;
         if (step) begin
            wr_line <= wr_mode ? {sense[LINE_W], out_half ^ cpl} : '0;
            if (deliver) begin
               rd_byte <= rev ? swap_h(filled) : filled;
               rd_rev  <= rev;
            end
            if (close_bad) ck_err <= 1'b1;
            if ((deliver & ~chan_ready) | (take & ~chan_wvalid)) incomplete <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/tbp_checker.sv
module tbp_checker #(
   parameter int LINE_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            step,
   input logic            wr_mode,
   input logic            ck_slot,
   input logic [LINE_W:0] wr_line,
   input logic            rd_valid,
   input logic            wr_take,
   input logic            ck_err,
   input logic            incomplete
);
   p_rd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   p_rd_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(step) && !$past(wr_mode)));
   p_rd_noslot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !$past(ck_slot));
   p_take_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_take |-> ($past(step) && $past(wr_mode) && !$past(ck_slot)));
   p_take_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_take |=> !wr_take);
   p_line_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(step) && !$past(wr_mode)) |-> (wr_line == '0));
   p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ck_err |=> ck_err);
   p_inc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      incomplete |=> incomplete);
endmodule

bind tape_byte_packer tbp_checker #(.LINE_W(LINE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .step       (step),
   .wr_mode    (wr_mode),
   .ck_slot    (ck_slot),
   .wr_line    (wr_line),
   .rd_valid   (rd_valid),
   .wr_take    (wr_take),
   .ck_err     (ck_err),
   .incomplete (incomplete)
);

// File: tb/tb_tape_byte_packer.sv
`timescale 1ns/1ps
module tb_tape_byte_packer;
   logic       clk = 0, rst_n = 0, step = 0;
   logic [3:0] sense = 0;
   logic       rev = 0, wr_mode = 0, blk_active = 0, ck_slot = 0, ck_open = 0, blk_close = 0;
   logic [5:0] chan_wdata = 0;
   logic       chan_wvalid = 1, chan_ready = 1;
   logic [3:0] wr_line;
   logic       rd_valid, rd_rev, wr_take, ck_err, incomplete;
   logic [5:0] rd_byte;

   int n_chk = 0, n_bad = 0;
   logic [5:0] m_b, m_lb;
   logic m_ph, m_err, m_inc;
   logic [3:0] e_line;
   logic e_rv, e_take, e_rr;
   logic [5:0] e_rb;

   always #5 clk = ~clk;

   tape_byte_packer dut (.*);

   function automatic logic [5:0] sw(input logic [5:0] v);
      return {v[2:0], v[5:3]};
   endfunction

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 0; step = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      m_b = 0; m_lb = 0; m_ph = 0; m_err = 0; m_inc = 0;
      @(negedge clk);
      chk("R1 rd_valid", rd_valid, 0); chk("R1 wr_take", wr_take, 0);
      chk("R1 ck_err", ck_err, 0); chk("R1 incomplete", incomplete, 0);
      chk("R1 wr_line", wr_line, 0);
   endtask

   // reference model of one step, from the requirements
   task automatic model();
      logic [2:0] c; logic [5:0] src; logic fetch;
      c = rev ? 3'd7 : 3'd0;
      e_line = wr_mode ? {sense[3], (m_ph ? m_b[2:0] : m_b[5:3]) ^ c} : 4'd0;     // R7
      if (blk_active && !wr_mode) begin                                             // R2 R3
         if (m_ph) m_b[2:0] = m_b[2:0] | (sense[2:0] ^ c);
         else      m_b[5:3] = m_b[5:3] | (sense[2:0] ^ c);
      end
      e_rv = !wr_mode && blk_active && m_ph && !ck_slot;                           // R5
      if (e_rv) begin
         e_rb = rev ? sw(m_b) : m_b; e_rr = rev;
         if (!chan_ready) m_inc = 1;                                                // R11
      end
      if (ck_open) m_lb = 0;                                                        // R9
      if (m_ph) m_lb = m_lb ^ ~m_b;
      if (blk_close && blk_active && m_lb != 6'o77) m_err = 1;                     // R10
      fetch = wr_mode && blk_active && m_ph;
      e_take = fetch && !ck_slot;                                                   // R6
      if (blk_active && m_ph) begin
         src = ck_slot ? m_lb : chan_wdata;                                         // R8
         m_b = fetch ? (rev ? sw(src) : src) : 6'd0;                                // R12
         if (e_take && !chan_wvalid) m_inc = 1;
      end
      m_ph = blk_active && !m_ph;                                                   // R4
   endtask

   task automatic do_step();
      model();
      step = 1;
      @(negedge clk);
      step = 0;
      chk("R2 rd_valid", rd_valid, e_rv);
      if (e_rv) begin
         chk("R3 rd_byte", rd_byte, e_rb);
         chk("R3 rd_rev", rd_rev, e_rr);
      end
      chk("R6 wr_take", wr_take, e_take);
      chk("R7 wr_line", wr_line, e_line);
      chk("R10 ck_err", ck_err, m_err);
      chk("R11 incomplete", incomplete, m_inc);
      if ($urandom_range(0, 2) == 0) begin
         @(negedge clk);
         chk("R2 pulse end", rd_valid, 0);
         chk("R6 pulse end", wr_take, 0);
      end
   endtask

   task automatic set_in(input logic [3:0] s, input logic a, input logic sl,
                         input logic op, input logic cl);
      sense = s; blk_active = a; ck_slot = sl; ck_open = op; blk_close = cl;
   endtask

   initial begin
      void'($urandom(32'h5eed1234));
      do_reset();
      // directed: forward read, checksum passes (R9, R10)
      rev = 0; wr_mode = 0;
      set_in(4'h0, 1, 0, 1, 0); do_step();
      set_in(4'h0, 1, 0, 0, 0); do_step();
      set_in(4'h0, 1, 0, 0, 1); do_step();
      chk("R10 good close", ck_err, 0);
      set_in(4'h5, 1, 0, 0, 0); do_step();
      set_in(4'h1, 1, 0, 0, 1); do_step();
      chk("R10 bad close", ck_err, 1);
      // directed: reverse read with half swap (R3)
      do_reset(); rev = 1;
      set_in(4'h1, 1, 0, 0, 0); do_step();
      set_in(4'h6, 1, 0, 0, 0); do_step();
      chk("R3 reverse byte", rd_byte, 6'o16);
      // directed: inactive steps keep phase 0 (R4), then write fetch reverse (R12)
      do_reset(); rev = 1; wr_mode = 1; chan_wdata = 6'o52;
      set_in(4'h8, 0, 0, 0, 0); do_step(); do_step();
      set_in(4'h8, 1, 0, 0, 0); do_step(); do_step();
      set_in(4'h0, 1, 0, 0, 0); do_step();
      chk("R12 first line", wr_line, {1'b0, 3'o2 ^ 3'o7});
      // directed: checksum slot on write loads checksum (R8), no take (R5)
      set_in(4'h0, 1, 1, 0, 0); do_step(); do_step();
      // random sections
      for (int sec = 0; sec < 40; sec++) begin
         do_reset();
         rev = $urandom_range(0, 1); wr_mode = $urandom_range(0, 1);
         for (int k = 0; k < 50; k++) begin
            sense = $urandom_range(0, 15);
            blk_active = ($urandom_range(0, 9) != 0);
            ck_slot = ($urandom_range(0, 6) == 0);
            ck_open = ($urandom_range(0, 9) == 0);
            blk_close = ($urandom_range(0, 9) == 0);
            chan_wdata = $urandom_range(0, 63);
            chan_wvalid = ($urandom_range(0, 19) != 0);
            chan_ready = ($urandom_range(0, 19) != 0);
            if ($urandom_range(0, 9) == 0) rev = ~rev;
            do_step();
         end
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1500000;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule